// File: doc/BRIEF.md
# Triangle Wave Offset Generator

This block adds a triangle-shaped offset to a held 12-bit sample on its way to a converter. Each accepted trigger adds the present value of an internal triangle counter to the held sample. The sum is clipped at full scale and written to the output register a fixed number of clock cycles later. Only on that same edge does the counter take its next step, so each output carries the counter value that was current when the trigger arrived.

The counter rises by one per accepted trigger from zero to a peak, falls back to zero, and repeats. A 4-bit code sets the peak. Choosing the trigger source and driving the analog stage belong to neighbouring logic. A transfer runs from its accepting edge to its output edge, and triggers that arrive during that time are dropped. An enable input gates acceptance.

Top module: `triwave_offset_gen`

## Requirements
- R1: While reset is asserted and after it is released, `dataOut` is 0, the triangle counter is 0 and its direction is rising.
- R2: A trigger is accepted on a rising clock edge where `trigIn` and `enable` are both 1 and no transfer is in flight. The value loaded into `dataOut` is `heldData` plus the counter value, both sampled on that edge.
- R3: `dataOut` takes the new value on the third rising edge after the accepting edge. It does not change on the first or second edge after it, or at any edge that ends no transfer.
- R4: The counter steps exactly once per accepted trigger, on the edge that loads `dataOut`. The sum therefore uses the value from before the step.
- R5: For code n, the peak is 2^(n+1)-1 when n is 10 or less. For any code of 11 or more, the peak is 4095.
- R6: With a fixed code, successive accepted triggers see counter values 0, 1, …, peak, peak-1, …, 0, 1, … and so on.
- R7: A sum above 4095 is output as 4095 and never wraps.
- R8: A trigger seen on any of the three edges after an accepting edge is ignored. It neither starts a transfer nor steps the counter.
- R9: With `enable` at 0, a trigger is ignored. `dataOut` keeps its value and the counter does not step.
- R10: A change of `heldData` after the accepting edge does not affect the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger request, sampled each rising edge |
| enable | input | 1 | Allows triggers to be accepted when 1 |
| heldData | input | 12 | Held sample the offset is added to |
| ampCode | input | 4 | Triangle amplitude code |
| dataOut | output | 12 | Clipped sum, output register |

## Verification
Runs with a fixed code and a constant sample of zero show the bare counter sequence, so a wrong peak, a wrong turn-around or a skipped step is visible directly. Random samples at random codes and random idle gaps test the addition against changing inputs. A sample near full scale separates clipping from wrap-around. A trigger held high across a whole transfer, and one given with enable low, each show whether an extra counter step was taken. Changing the sample right after the accepting edge, and reading the output one edge before it is due, pin down the sampling edge and the three-cycle latency.

// File: rtl/twog_pkg.sv
package twog_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // trigger accepted this cycle: sample the sum
    logic transfer;  // transfer completes this cycle: load output, step counter
  } twogStrobes_t;
endpackage

// File: rtl/twog_ctrl.sv
module twog_ctrl
  import twog_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trigIn,
  input  logic         enable,
  output twogStrobes_t strobes
);
  localparam int PH_W = $clog2(LATENCY + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(LATENCY);

  logic [PH_W-1:0] phase;
  logic idle;

  assign idle             = (phase == '0);
  assign strobes.capture  = trigIn && enable && idle;
  assign strobes.transfer = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (strobes.capture) begin
      phase <= PH_W'(1);
    end else if (!idle) begin
      phase <= strobes.transfer ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/twog_datapath.sv
module twog_datapath
  import twog_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int AMP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  twogStrobes_t      strobes,
  input  logic [DATA_W-1:0] heldData,
  input  logic [AMP_W-1:0]  ampCode,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] triCount
);
  localparam logic [DATA_W-1:0] FULL = {DATA_W{1'b1}};
  localparam int SAT_CODE = DATA_W - 1;

  logic [DATA_W-1:0] peakVal;
  logic [DATA_W:0]   rawSum;
  logic [DATA_W-1:0] clipSum;
  logic [DATA_W-1:0] sumReg;
  logic              goingDown;
  logic [DATA_W-1:0] nextCount;
  logic              nextDown;

  always_comb begin
    if (int'(ampCode) >= SAT_CODE) peakVal = FULL;
    else                           peakVal = DATA_W'((1 << (int'(ampCode) + 1)) - 1);
  end

  assign rawSum  = {1'b0, heldData} + {1'b0, triCount};
  assign clipSum = rawSum[DATA_W] ? FULL : rawSum[DATA_W-1:0];

  always_comb begin
    nextCount = triCount;
    nextDown  = goingDown;
    if (!goingDown) begin
      if (triCount < peakVal) begin
        nextCount = triCount + DATA_W'(1);
        nextDown  = (nextCount >= peakVal);
      end else begin
        nextCount = triCount - DATA_W'(1);
        nextDown  = 1'b1;
      end
    end else begin
      if (triCount == '0) begin
        nextCount = DATA_W'(1);
        nextDown  = 1'b0;
      end else begin
        nextCount = triCount - DATA_W'(1);
        nextDown  = (nextCount != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sumReg    <= '0;
      dataOut   <= '0;
      triCount  <= '0;
      goingDown <= 1'b0;
    end else begin
      if (strobes.capture) sumReg <= clipSum;
      if (strobes.transfer) begin
        dataOut   <= sumReg;
        triCount  <= nextCount;
        goingDown <= nextDown;
      end
    end
  end
endmodule

// File: rtl/triwave_offset_gen.sv
module triwave_offset_gen
  import twog_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int AMP_W   = 4,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigIn,
  input  logic              enable,
  input  logic [DATA_W-1:0] heldData,
  input  logic [AMP_W-1:0]  ampCode,
  output logic [DATA_W-1:0] dataOut
);
  twogStrobes_t      strobes;
  logic [DATA_W-1:0] triCount;

  twog_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigIn  (trigIn),
    .enable  (enable),
    .strobes (strobes)
  );

  twog_datapath #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .heldData (heldData),
    .ampCode  (ampCode),
    .dataOut  (dataOut),
    .triCount (triCount)
  );
endmodule

// File: rtl/twog_chk.sv
module twog_chk #(
  parameter int DATA_W  = 12,
  parameter int LATENCY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capture,
  input logic              transfer,
  input logic [DATA_W-1:0] dataOut,
  input logic [DATA_W-1:0] triCount
);
  int sinceCap;

  always_ff @(posedge clk) begin
    if (!rst_n)                           sinceCap <= 0;
    else if (capture)                     sinceCap <= 1;
    else if (transfer)                    sinceCap <= 0;
    else if (sinceCap != 0 && sinceCap < LATENCY) sinceCap <= sinceCap + 1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transfer |-> sinceCap == LATENCY);

  // R8
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> sinceCap == 0);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !transfer |=> $stable(dataOut));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !transfer |=> $stable(triCount));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transfer |=> (triCount == $past(triCount) + DATA_W'(1)) ||
                 (triCount == $past(triCount) - DATA_W'(1)));
endmodule

bind triwave_offset_gen twog_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .capture  (strobes.capture),
  .transfer (strobes.transfer),
  .dataOut  (dataOut),
  .triCount (triCount)
);

// File: tb/triwave_offset_gen_tb.sv
module triwave_offset_gen_tb;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigIn = 1'b0;
  logic        enable = 1'b1;
  logic [11:0] heldData = '0;
  logic [3:0]  ampCode = '0;
  logic [11:0] dataOut;

  int checks = 0;
  int fails  = 0;
  int mCnt   = 0;
  bit mDown  = 0;

  always #(PERIOD/2) clk = ~clk;

  triwave_offset_gen u_dut (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .enable(enable),
    .heldData(heldData), .ampCode(ampCode), .dataOut(dataOut)
  );

  function automatic int peakOf(input int code);
    return (code >= 11) ? 4095 : ((1 << (code + 1)) - 1);
  endfunction

  function automatic int satSum(input int a, input int b);
    return (a + b > 4095) ? 4095 : a + b;
  endfunction

  task automatic modelStep();
    int pk = peakOf(int'(ampCode));
    if (!mDown) begin
      mCnt++;
      if (mCnt >= pk) mDown = 1;
    end else begin
      mCnt--;
      if (mCnt == 0) mDown = 0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; trigIn = 1'b0;
    @(negedge clk);
    check(dataOut == 0, "R1 output in reset", dataOut, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mCnt = 0; mDown = 0;
    @(negedge clk);
    check(dataOut == 0, "R1 output after reset", dataOut, 0);
  endtask

  // one trigger: optional hold of trigIn across the transfer (R8)
  task automatic doTrig(input logic [11:0] held, input bit en, input bit holdHigh, input string tag);
    logic [11:0] prev;
    int expv;
    prev = dataOut;
    heldData = held; enable = en; trigIn = 1'b1;
    @(negedge clk);                        // accepting edge has passed
    if (!holdHigh) trigIn = 1'b0;
    heldData = ~held;                      // R10 disturbance
    @(negedge clk);
    @(negedge clk);                        // two edges after accept
    check(dataOut == prev, {tag, " R3 early"}, dataOut, prev);
    @(negedge clk);                        // third edge
    trigIn = 1'b0; enable = 1'b1;
    if (en) begin
      expv = satSum(int'(held), mCnt);
      check(dataOut == expv, {tag, " R2"}, dataOut, expv);
      modelStep();
    end else begin
      check(dataOut == prev, {tag, " R9"}, dataOut, prev);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    doReset();

    // R1 R4: first trigger after reset adds counter value 0
    ampCode = 4'd2;
    doTrig(12'd100, 1'b1, 1'b0, "R1 first");

    // R6 R5: triangle for code 2 (peak 7)
    doReset();
    for (int i = 0; i < 20; i++) doTrig(12'd0, 1'b1, 1'b0, "R6 code2");

    // R5: code 0, peak 1
    doReset(); ampCode = 4'd0;
    for (int i = 0; i < 6; i++) doTrig(12'd50, 1'b1, 1'b0, "R5 code0");

    // R7: clipping near full scale
    doReset(); ampCode = 4'd3;
    for (int i = 0; i < 12; i++) doTrig(12'd4090, 1'b1, 1'b0, "R7 clip");
    check(dataOut == 4095, "R7 held clipped", dataOut, 4095);

    // R8: trigger kept high over the whole transfer steps only once
    doReset(); ampCode = 4'd4;
    doTrig(12'd10, 1'b1, 1'b1, "R8 hold");
    doTrig(12'd10, 1'b1, 1'b0, "R8 after");
    check(mCnt == 2, "R8 model count", mCnt, 2);

    // R9: disabled trigger ignored, next one sees unstepped counter
    doTrig(12'd200, 1'b0, 1'b0, "R9 off");
    doTrig(12'd200, 1'b1, 1'b0, "R9 after");

    // random segments
    for (int s = 0; s < 6; s++) begin
      doReset();
      ampCode = 4'($urandom_range(0, 15));
      for (int i = 0; i < 40; i++) begin
        int gap = int'($urandom_range(0, 3));
        for (int g = 0; g < gap; g++) @(negedge clk);
        doTrig(12'($urandom_range(0, 4095)), 1'b1, 1'b0, "R2 random");
      end
    end

    // R5: code 15 saturates to peak 4095
    doReset(); ampCode = 4'd15;
    for (int i = 0; i < 4096; i++) doTrig(12'd0, 1'b1, 1'b0, "R5 code15");
    check(dataOut == 4095, "R5 peak reached", dataOut, 4095);
    doTrig(12'd0, 1'b1, 1'b0, "R6 turn");
    check(dataOut == 4094, "R6 turn down", dataOut, 4094);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule